// File: doc/BRIEF.md
# Switching Controller Fault Supervisor

This block is the supervisory state machine of a current-mode switching power controller. It decides when the power switch may be driven, and how the controller stops and recovers after a supply or protection event. Its inputs are supply comparator flags and fault flags that are already filtered. Its outputs are a switching enable, a startup-current request and a soft-start indication. The analog detectors and the model of the supply ramping up and down are outside this block.

The faults fall into three classes. The first class is brown-out, over-temperature and a shorted current-sense input. These drop the controller into a discharge state, which waits for the supply to collapse. The second class is supply overvoltage. It always starts a long auto-restart timer. The third class is a winding or diode short, or a short on the auxiliary input. A version select sends this class either to the auto-restart timer or to a latch, and only a deep supply reset releases the latch. When the brown-out flag clears during the discharge state, the controller restarts at once.

Top module: `fault_supervisor`

## Requirements
- R1: After reset the block is in its idle state: `startupCurrent` is 1, and `switchEn` and `softStart` are 0.
- R2: From idle, `supplyAboveOn` at a clock edge moves the block to a one-cycle standby, in which all outputs are 0. It then moves to run at the next edge. `switchEn` is 1 only in run.
- R3: In standby or run, a brown-out, over-temperature or current-sense-short flag moves the block to the discharge state, in which all outputs are 0. The block stays there until `supplyBelowOff` is 1, then returns to idle.
- R4: In the discharge state, a falling edge of `faultBrownOut` (1 at one edge, 0 at the next) returns the block to idle at that edge, whatever the value of `supplyBelowOff`.
- R5: With `latchVersion` = 0, an overvoltage, winding-short or aux-short flag in standby or run starts the restart timer. The block leaves the timer state only after `RECOVER_CYCLES` further edges, and only when `supplyAboveOn` is 1. It waits while that flag is 0. It then passes through standby to run.
- R6: With `latchVersion` = 1, a winding-short or aux-short flag in standby or run enters the latch. The latch ignores `supplyAboveOn` and `supplyBelowOff`, and only `supplyBelowReset` returns the block to idle.
- R7: With `latchVersion` = 1, an overvoltage flag still takes the timed restart path of R5.
- R8: In standby or run with no fault flag set, `supplyBelowOff` returns the block to idle.
- R9: On each entry to run, `softStart` is 1 for the first `SOFT_CYCLES` cycles and then 0.
- R10: Fault priority in standby or run is latch class first, then timer class, then discharge class, then undervoltage. In idle, a discharge-class flag blocks the move to standby.
- R11: Fault flags have no effect while the block is in the timer or latch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| latchVersion | input | 1 | 1 = latched handling of shorts, 0 = auto-restart |
| supplyAboveOn | input | 1 | Supply is above the start level |
| supplyBelowOff | input | 1 | Supply is below the undervoltage level |
| supplyBelowReset | input | 1 | Supply is below the deep reset level |
| faultBrownOut | input | 1 | Input line too low |
| faultOverTemp | input | 1 | Die over temperature |
| faultCsShort | input | 1 | Current-sense input shorted |
| faultSupplyOv | input | 1 | Supply overvoltage (open load) |
| faultWindingShort | input | 1 | Winding or output diode short |
| faultAuxShort | input | 1 | Output or auxiliary winding short |
| switchEn | output | 1 | Power switch may be driven |
| startupCurrent | output | 1 | Startup-current mode request |
| softStart | output | 1 | Soft-start interval in progress |

## Verification
Several properties are checked on every cycle: switching only ever begins from the standby state, and soft-start is never active without switching. The checks also cover that the latch and discharge states hold until their own release condition, that the timer state can only exit towards standby, and that a brown-out flag in idle blocks startup. Other behaviour depends on a sequence of inputs, so only the bench scenarios can show it. This covers the exact length of the restart timer, waiting for the supply at timer expiry, and the version select routing the same short to the timer or to the latch. It also covers which of two simultaneous faults wins, which the bench shows through the different way each state exits.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_STANDBY = 3'd1,
    ST_RUN     = 3'd2,
    ST_DISCH   = 3'd3,
    ST_RECOVER = 3'd4,
    ST_LATCH   = 3'd5
  } supState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic inRecover;
    logic inRun;
  } ctlStrobe_t;

  // status from the timer datapath back to control
  typedef struct packed {
    logic recoverDone;
    logic softActive;
    logic boFall;
  } dpStatus_t;

endpackage

// File: rtl/fsup_timers.sv
module fsup_timers
  import fsup_pkg::*;
#(
  parameter int RECOVER_CYCLES = 500_000_000,
  parameter int SOFT_CYCLES    = 5_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       brownOut,
  output dpStatus_t  status
);

  localparam int RW = $clog2(RECOVER_CYCLES + 1);
  localparam int SW = $clog2(SOFT_CYCLES + 1);
  localparam logic [RW-1:0] REC_LIM  = RW'(RECOVER_CYCLES);
  localparam logic [SW-1:0] SOFT_LIM = SW'(SOFT_CYCLES);

  logic [RW-1:0] recCnt;
  logic [SW-1:0] softCnt;
  logic          boPrev;

  // restart timer: held at zero outside the timer state, saturates at limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    recCnt <= '0;
    else if (!strobe.inRecover)   recCnt <= '0;
    else if (recCnt != REC_LIM)   recCnt <= recCnt + 1'b1;
  end

  // soft-start counter: restarts on every entry to run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    softCnt <= '0;
    else if (!strobe.inRun)       softCnt <= '0;
    else if (softCnt != SOFT_LIM) softCnt <= softCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) boPrev <= 1'b0;
    else       boPrev <= brownOut;
  end

  always_comb begin
    status.recoverDone = (recCnt == REC_LIM);
    status.softActive  = strobe.inRun && (softCnt != SOFT_LIM);
    status.boFall      = boPrev && !brownOut;
  end

endmodule

// File: rtl/fsup_control.sv
module fsup_control
  import fsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchVersion,
  input  logic       supplyAboveOn,
  input  logic       supplyBelowOff,
  input  logic       supplyBelowReset,
  input  logic       faultBrownOut,
  input  logic       faultOverTemp,
  input  logic       faultCsShort,
  input  logic       faultSupplyOv,
  input  logic       faultWindingShort,
  input  logic       faultAuxShort,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output supState_t  state
);

  supState_t nextState;
  logic dischFault, timerFault, latchFault, shortFault;

  always_comb begin
    shortFault = faultWindingShort | faultAuxShort;
    dischFault = faultBrownOut | faultOverTemp | faultCsShort;
    latchFault = latchVersion & shortFault;
    timerFault = faultSupplyOv | (~latchVersion & shortFault);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:
        if (supplyAboveOn && !dischFault) nextState = ST_STANDBY;
      ST_STANDBY, ST_RUN: begin
        if (latchFault)          nextState = ST_LATCH;
        else if (timerFault)     nextState = ST_RECOVER;
        else if (dischFault)     nextState = ST_DISCH;
        else if (supplyBelowOff) nextState = ST_IDLE;
        else                     nextState = ST_RUN;
      end
      ST_DISCH:
        if (supplyBelowOff || status.boFall) nextState = ST_IDLE;
      ST_RECOVER:
        if (status.recoverDone && supplyAboveOn) nextState = ST_STANDBY;
      ST_LATCH:
        if (supplyBelowReset) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.inRecover = (state == ST_RECOVER);
    strobe.inRun     = (state == ST_RUN);
  end

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int RECOVER_CYCLES = 500_000_000,
  parameter int SOFT_CYCLES    = 5_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic latchVersion,
  input  logic supplyAboveOn,
  input  logic supplyBelowOff,
  input  logic supplyBelowReset,
  input  logic faultBrownOut,
  input  logic faultOverTemp,
  input  logic faultCsShort,
  input  logic faultSupplyOv,
  input  logic faultWindingShort,
  input  logic faultAuxShort,
  output logic switchEn,
  output logic startupCurrent,
  output logic softStart
);

  ctlStrobe_t strobe;
  dpStatus_t  status;
  supState_t  curState;

  fsup_control u_ctl (
    .clk              (clk),
    .rstN             (rstN),
    .latchVersion     (latchVersion),
    .supplyAboveOn    (supplyAboveOn),
    .supplyBelowOff   (supplyBelowOff),
    .supplyBelowReset (supplyBelowReset),
    .faultBrownOut    (faultBrownOut),
    .faultOverTemp    (faultOverTemp),
    .faultCsShort     (faultCsShort),
    .faultSupplyOv    (faultSupplyOv),
    .faultWindingShort(faultWindingShort),
    .faultAuxShort    (faultAuxShort),
    .status           (status),
    .strobe           (strobe),
    .state            (curState)
  );

  fsup_timers #(
    .RECOVER_CYCLES(RECOVER_CYCLES),
    .SOFT_CYCLES   (SOFT_CYCLES)
  ) u_tmr (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .brownOut(faultBrownOut),
    .status  (status)
  );

  assign switchEn       = (curState == ST_RUN);
  assign startupCurrent = (curState == ST_IDLE);
  assign softStart      = status.softActive;

endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk
  import fsup_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      supplyBelowOff,
  input logic      supplyBelowReset,
  input logic      faultBrownOut,
  input logic      faultOverTemp,
  input logic      faultCsShort,
  input logic      faultSupplyOv,
  input logic      faultWindingShort,
  input logic      faultAuxShort,
  input logic      switchEn,
  input logic      startupCurrent,
  input logic      softStart,
  input supState_t curState
);

  logic anyFault;
  assign anyFault = faultBrownOut | faultOverTemp | faultCsShort |
                    faultSupplyOv | faultWindingShort | faultAuxShort;

  // R1: the startup-current request and switching never overlap
  a_r1_idle_no_switch: assert property (@(posedge clk) disable iff (!rstN)
    startupCurrent |-> !switchEn);

  // R2: switching only ever begins from standby
  a_r2_run_from_standby: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchEn) |-> $past(curState) == ST_STANDBY);

  // R3: discharge holds until the off level or a brown-out release
  a_r3_disch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_DISCH && !supplyBelowOff && !($past(faultBrownOut) && !faultBrownOut))
      |=> curState == ST_DISCH);

  // R4: brown-out falling edge releases discharge at once
  a_r4_bo_release: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_DISCH && $past(faultBrownOut) && !faultBrownOut)
      |=> curState == ST_IDLE);

  // R5 / R11: the timer state only exits towards standby
  a_r5_timer_exit: assert property (@(posedge clk) disable iff (!rstN)
    curState == ST_RECOVER |=> (curState == ST_RECOVER || curState == ST_STANDBY));

  // R6: the latch is released only by the deep reset level
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_LATCH && !supplyBelowReset) |=> curState == ST_LATCH);

  // R8: undervoltage in run with no fault returns to idle
  a_r8_uvlo: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_RUN && supplyBelowOff && !anyFault) |=> curState == ST_IDLE);

  // R9: soft-start only ever shows while switching
  a_r9_soft_in_run: assert property (@(posedge clk) disable iff (!rstN)
    softStart |-> switchEn);

  // R10: a discharge-class flag blocks startup from idle
  a_r10_idle_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && (faultBrownOut | faultOverTemp | faultCsShort))
      |=> curState == ST_IDLE);

endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .supplyBelowOff   (supplyBelowOff),
  .supplyBelowReset (supplyBelowReset),
  .faultBrownOut    (faultBrownOut),
  .faultOverTemp    (faultOverTemp),
  .faultCsShort     (faultCsShort),
  .faultSupplyOv    (faultSupplyOv),
  .faultWindingShort(faultWindingShort),
  .faultAuxShort    (faultAuxShort),
  .switchEn         (switchEn),
  .startupCurrent   (startupCurrent),
  .softStart        (softStart),
  .curState         (curState)
);

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;

  localparam int RC = 40;
  localparam int SC = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchVersion = 1'b0;
  logic supplyAboveOn = 1'b0, supplyBelowOff = 1'b1, supplyBelowReset = 1'b1;
  logic faultBrownOut = 1'b0, faultOverTemp = 1'b0, faultCsShort = 1'b0;
  logic faultSupplyOv = 1'b0, faultWindingShort = 1'b0, faultAuxShort = 1'b0;
  logic switchEn, startupCurrent, softStart;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  string      reqQ[$];
  logic [2:0] expQ[$];

  always #4 clk = ~clk;

  fault_supervisor #(.RECOVER_CYCLES(RC), .SOFT_CYCLES(SC)) u_dut (
    .clk(clk), .rstN(rstN), .latchVersion(latchVersion),
    .supplyAboveOn(supplyAboveOn), .supplyBelowOff(supplyBelowOff),
    .supplyBelowReset(supplyBelowReset), .faultBrownOut(faultBrownOut),
    .faultOverTemp(faultOverTemp), .faultCsShort(faultCsShort),
    .faultSupplyOv(faultSupplyOv), .faultWindingShort(faultWindingShort),
    .faultAuxShort(faultAuxShort), .switchEn(switchEn),
    .startupCurrent(startupCurrent), .softStart(softStart)
  );

  // driver helpers: inputs change 1 ns after a rising edge
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected {switchEn, startupCurrent, softStart}
  task automatic expectOut(input string req, input bit en, input bit su, input bit ss);
    reqQ.push_back(req);
    expQ.push_back({en, su, ss});
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      string r;
      logic [2:0] e;
      r = reqQ.pop_front();
      e = expQ.pop_front();
      checks++;
      if ({switchEn, startupCurrent, softStart} !== e) begin
        fails++;
        $display("FAIL %s: actual en/su/ss=%b expected %b", r,
                 {switchEn, startupCurrent, softStart}, e);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    expectOut("R1 reset state", 0, 1, 0);

    // R10: brown-out present in idle blocks startup
    supplyAboveOn = 1; supplyBelowOff = 0; supplyBelowReset = 0; faultBrownOut = 1;
    cyc(2);
    expectOut("R10 idle blocked by brown-out", 0, 1, 0);

    faultBrownOut = 0;
    cyc(1); expectOut("R2 standby", 0, 0, 0);
    cyc(1); expectOut("R2 run / R9 soft on", 1, 0, 1);
    cyc(SC - 1); expectOut("R9 soft last cycle", 1, 0, 1);
    cyc(1); expectOut("R9 soft ended", 1, 0, 0);

    // R8 undervoltage
    supplyBelowOff = 1;
    cyc(1); expectOut("R8 uvlo to idle", 0, 1, 0);
    supplyBelowOff = 0;
    cyc(2); expectOut("R8 restart run", 1, 0, 1);

    // R3 discharge on over-temperature
    faultOverTemp = 1;
    cyc(1); expectOut("R3 discharge entered", 0, 0, 0);
    faultOverTemp = 0;
    cyc(3); expectOut("R3 discharge holds", 0, 0, 0);
    supplyBelowOff = 1;
    cyc(1); expectOut("R3 off level to idle", 0, 1, 0);
    supplyBelowOff = 0;
    cyc(1); expectOut("R3 standby", 0, 0, 0);
    cyc(1); expectOut("R3 run again", 1, 0, 1);

    // R4 brown-out exit bypasses the off level
    faultBrownOut = 1;
    cyc(1); expectOut("R4 discharge on brown-out", 0, 0, 0);
    cyc(2); expectOut("R4 discharge holds", 0, 0, 0);
    faultBrownOut = 0;
    cyc(1); expectOut("R4 falling edge to idle", 0, 1, 0);
    cyc(2); expectOut("R4 run again", 1, 0, 1);

    // R5 auto version, aux short, R11 fault inside timer ignored
    latchVersion = 0;
    faultAuxShort = 1;
    cyc(1); expectOut("R5 timer entered", 0, 0, 0);
    faultAuxShort = 0;
    cyc(10);
    faultOverTemp = 1;
    cyc(1);
    faultOverTemp = 0;
    cyc(RC - 11); expectOut("R5 timer still running", 0, 0, 0);
    cyc(1); expectOut("R5 standby after timer", 0, 0, 0);
    cyc(1); expectOut("R5 R11 run after timer", 1, 0, 1);

    // R5 waits for the on level at expiry
    faultWindingShort = 1;
    cyc(1);
    faultWindingShort = 0; supplyAboveOn = 0;
    cyc(RC + 5); expectOut("R5 waits for on level", 0, 0, 0);
    supplyAboveOn = 1;
    cyc(1); expectOut("R5 standby on level", 0, 0, 0);
    cyc(1); expectOut("R5 run on level", 1, 0, 1);

    // R7 latched version, overvoltage still auto-restarts
    latchVersion = 1;
    faultSupplyOv = 1;
    cyc(1); expectOut("R7 timer entered", 0, 0, 0);
    faultSupplyOv = 0;
    cyc(RC + 1); expectOut("R7 standby after timer", 0, 0, 0);
    cyc(1); expectOut("R7 run after timer", 1, 0, 1);

    // R6 latch on winding short
    faultWindingShort = 1;
    cyc(1); expectOut("R6 latch entered", 0, 0, 0);
    faultWindingShort = 0;
    cyc(RC + 5); expectOut("R6 latch ignores on level", 0, 0, 0);
    supplyBelowOff = 1; faultOverTemp = 1;
    cyc(2); expectOut("R6 R11 latch ignores off level and faults", 0, 0, 0);
    faultOverTemp = 0; supplyBelowReset = 1;
    cyc(1); expectOut("R6 deep reset releases", 0, 1, 0);
    supplyBelowReset = 0; supplyBelowOff = 0;
    cyc(2); expectOut("R6 run again", 1, 0, 1);

    // R10 latch class wins over discharge class
    faultOverTemp = 1; faultAuxShort = 1;
    cyc(1);
    faultOverTemp = 0; faultAuxShort = 0; supplyBelowOff = 1;
    cyc(2); expectOut("R10 latch beats discharge", 0, 0, 0);
    supplyBelowReset = 1;
    cyc(1); expectOut("R10 latch released", 0, 1, 0);

    cyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule